// File: doc/BRIEF.md
# Morton-Order Address Generator

This block maps pairs of 2D coordinates into Z-order (Morton) codes and back, and it walks a loop index through Morton space at one element per cycle. The interleave path and the de-interleave path are purely combinational. Either one can sit directly on an address-forming path without adding latency.

The walker takes a loop bound `p` when it is started. It then produces a spread-form index `k` for every enabled cycle, until `k` reaches `p`. For each step it gives two word offsets:

- the row-operand offset, which is `k` spread onto the even bit positions;
- the column-operand offset, which is that same value moved onto the odd positions.

A dot-product style inner loop can add these offsets to its two operand bases. The index is never re-interleaved. It advances in spread form with a masked subtract and AND, and the bound is compared in spread form.

Top module: `morton_addr_gen`

## Requirements
- R1: `mix_code` is a 32-bit word whose bits alternate from the MSB down: `mix_a[15]` at bit 31, `mix_b[15]` at bit 30, `mix_a[14]` at bit 29, and so on down to `mix_b[0]` at bit 0. It depends on the current inputs only, with no clock cycle of latency.
- R2: `split_word[31:16]` holds the odd-position bits of `split_code` (bit 31 down to bit 1) in order. `split_word[15:0]` holds the even-position bits (bit 30 down to bit 0) in order. There is no latency.
- R3: Feeding `mix_code` into `split_code` returns `{mix_a, mix_b}` exactly, for every operand value.
- R4: When `rst_n` is low at a clock edge, `walk_valid` and `walk_done` are low afterwards, until a start is seen.
- R5: A start (`walk_start` high at an edge) loads index 0 and the bound `walk_limit`. In that start cycle itself, `walk_valid` is low.
- R6: In the cycles after a start, `walk_valid` is high exactly when `walk_en` is high and the index is below the bound. The index advances by one only on such cycles and holds otherwise. `row_off` always lies within the mask 0x55555555.
- R7: `row_off` equals the even-position spread of the current index `k`. `col_off` equals `row_off` shifted left by one bit, which is the spread of `k` on the odd positions.
- R8: After `p` valid cycles, with offsets for k = 0 .. p-1, `walk_done` rises. It stays high with `walk_valid` low until the next start.
- R9: A start with `walk_limit` = 0 gives `walk_done` in the next cycle, and no valid cycle occurs.
- R10: A start while a walk is in progress abandons that walk and restarts from index 0 with the new bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mix_a | input | 16 | Interleave operand placed on odd bit positions |
| mix_b | input | 16 | Interleave operand placed on even bit positions |
| mix_code | output | 32 | Interleaved Morton code |
| split_code | input | 32 | Morton code to separate |
| split_word | output | 32 | Odd-position bits in the high half, even-position bits in the low half |
| walk_start | input | 1 | Begin a new walk (index 0, bound sampled) |
| walk_limit | input | 16 | Loop bound p, sampled on start |
| walk_en | input | 1 | Permit one step this cycle |
| walk_valid | output | 1 | Offsets are valid this cycle |
| walk_done | output | 1 | Index has reached the bound |
| row_off | output | 32 | Row-operand word offset (spread index) |
| col_off | output | 32 | Column-operand word offset (row offset doubled) |

## Verification
The interleave and de-interleave results have no latency. The bench changes their inputs on the falling edge and compares the outputs one time unit later, in the same cycle.

For the walker, a start applied before a rising edge takes effect at that edge. The first offset (k = 0) and the validity for that step are then checked at the next falling edge. Each later step moves by exactly one edge, so the bench compares at every falling edge against a spread value that it computes for itself. A zero bound is checked in the same way: `walk_done` is read at the first falling edge after the start edge.

// File: rtl/morton_pkg.sv
// Package: shared constants and types for the Morton address generator.
// Assumes coordinates are at most 16 bits, giving a code twice as wide.
package morton_pkg;

    localparam int COORD_W_DEF = 16;

    // Walker states: idle (never started), walking, finished.
    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_RUN  = 2'd1,
        WALK_FIN  = 2'd2
    } walk_state_e;

endpackage

// File: rtl/morton_interleave.sv
// Module: morton_interleave
// Purely combinational bit interleave. Operand a lands on odd bit
// positions and operand b on even positions, MSB first.
// Assumes CODE_W = 2 * COORD_W.
module morton_interleave #(
    parameter int COORD_W = 16,
    localparam int CODE_W = 2 * COORD_W
) (
    input  logic [COORD_W-1:0] a_in,
    input  logic [COORD_W-1:0] b_in,
    output logic [CODE_W-1:0]  code_out
);

    // One pair of code bits per coordinate bit.
    for (genvar i = 0; i < COORD_W; i++) begin : g_pair
        assign code_out[2*i+1] = a_in[i];
        assign code_out[2*i]   = b_in[i];
    end

endmodule

// File: rtl/morton_deinterleave.sv
// Module: morton_deinterleave
// Purely combinational bit gather. Odd-position bits form the high half
// of the result, even-position bits form the low half, in order.
module morton_deinterleave #(
    parameter int COORD_W = 16,
    localparam int CODE_W = 2 * COORD_W
) (
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] word_out
);

    // Route each code bit to its half.
    for (genvar i = 0; i < COORD_W; i++) begin : g_gather
        assign word_out[COORD_W+i] = code_in[2*i+1];
        assign word_out[i]         = code_in[2*i];
    end

endmodule

// File: rtl/morton_stepper.sv
// Module: morton_stepper
// Walks a spread-form index from spread(0) up to the spread bound that it
// is given at start. It steps once per enabled cycle with a masked
// subtract-and-AND. The bound is compared in spread form, which is valid
// because spreading preserves unsigned order.
// Assumes lim_spread already holds only even-position bits.
module morton_stepper #(
    parameter int COORD_W = 16,
    localparam int CODE_W = 2 * COORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] lim_spread,
    input  logic              enable,
    output logic              valid,
    output logic              done,
    output logic [CODE_W-1:0] idx_spread
);
    import morton_pkg::*;

    localparam logic [CODE_W-1:0] EVEN_MASK = {COORD_W{2'b01}};

    walk_state_e       state_q;
    logic [CODE_W-1:0] idx_q;
    logic [CODE_W-1:0] lim_q;
    logic [CODE_W-1:0] idx_next;
    logic              below;

    // Spread-form compare of the index against the stored bound.
    always_comb below = (idx_q < lim_q);

    // Spread-form increment: subtract the mask, keep the even lanes.
    always_comb idx_next = (idx_q - EVEN_MASK) & EVEN_MASK;

    // Walk state, index and bound registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
            lim_q   <= '0;
        end else if (start) begin
            state_q <= (lim_spread == '0) ? WALK_FIN : WALK_RUN;
            idx_q   <= '0;
            lim_q   <= lim_spread;
        end else if (state_q == WALK_RUN && enable && below) begin
            idx_q   <= idx_next;
            state_q <= (idx_next < lim_q) ? WALK_RUN : WALK_FIN;
        end
    end

    // Output decode: valid only on a live, enabled step.
    always_comb begin
        valid      = (state_q == WALK_RUN) && enable && !start && below;
        done       = (state_q == WALK_FIN);
        idx_spread = idx_q;
    end

endmodule

// File: rtl/morton_addr_gen.sv
// Module: morton_addr_gen (top)
// Combinational Morton interleave and de-interleave, and a spread-form
// loop walker. The walker emits row and column operand offsets.
// Its bound is spread through a second interleave, with the bound on
// the even lanes.
module morton_addr_gen #(
    parameter int COORD_W = morton_pkg::COORD_W_DEF,
    localparam int CODE_W = 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] mix_a,
    input  logic [COORD_W-1:0] mix_b,
    output logic [CODE_W-1:0]  mix_code,
    input  logic [CODE_W-1:0]  split_code,
    output logic [CODE_W-1:0]  split_word,
    input  logic               walk_start,
    input  logic [COORD_W-1:0] walk_limit,
    input  logic               walk_en,
    output logic               walk_valid,
    output logic               walk_done,
    output logic [CODE_W-1:0]  row_off,
    output logic [CODE_W-1:0]  col_off
);

    logic [CODE_W-1:0] lim_spread;
    logic [CODE_W-1:0] idx_spread;

    // User-facing interleave path.
    morton_interleave #(.COORD_W(COORD_W)) u_mix (
        .a_in     (mix_a),
        .b_in     (mix_b),
        .code_out (mix_code)
    );

    // User-facing de-interleave path.
    morton_deinterleave #(.COORD_W(COORD_W)) u_split (
        .code_in  (split_code),
        .word_out (split_word)
    );

    // Bound spreading: the bound sits on the even lanes, with a zero partner.
    morton_interleave #(.COORD_W(COORD_W)) u_lim_spread (
        .a_in     ('0),
        .b_in     (walk_limit),
        .code_out (lim_spread)
    );

    // Spread-form loop walker.
    morton_stepper #(.COORD_W(COORD_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .lim_spread (lim_spread),
        .enable     (walk_en),
        .valid      (walk_valid),
        .done       (walk_done),
        .idx_spread (idx_spread)
    );

    // Column offset is the row offset moved onto the odd lanes.
    always_comb begin
        row_off = idx_spread;
        col_off = {idx_spread[CODE_W-2:0], 1'b0};
    end

endmodule

// File: rtl/morton_addr_gen_chk.sv
// Module: morton_addr_gen_chk
// Checker bound to morton_addr_gen. It holds the temporal properties of
// the walker ports.
module morton_addr_gen_chk #(
    parameter int COORD_W = 16,
    localparam int CODE_W = 2 * COORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              walk_start,
    input logic              walk_en,
    input logic              walk_valid,
    input logic              walk_done,
    input logic [CODE_W-1:0] row_off,
    input logic [CODE_W-1:0] col_off
);
    localparam logic [CODE_W-1:0] EVEN_MASK = {COORD_W{2'b01}};

    // R4: reset clears both handshake outputs.
    p_reset_clear_r4: assert property (@(posedge clk)
        !rst_n |=> (!walk_valid && !walk_done));

    // R5: no valid step in a start cycle.
    p_start_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |-> !walk_valid);

    // R6: index stays on the even lanes.
    p_even_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_off & ~EVEN_MASK) == '0);

    // R6: index holds when no step and no start occur.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!walk_valid && !walk_start) |=> $stable(row_off));

    // R6: a valid step strictly increases the index, unless a start follows.
    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid |=> (walk_start || row_off > $past(row_off)));

    // R7: column offset sits exactly one lane above the row offset.
    p_col_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_off >> 1) == row_off);

    // R8: done and valid never coexist.
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> !walk_valid);

    // R8: done holds until a start.
    p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_start) |=> walk_done);

    // R6: no valid while the enable is low.
    p_no_en_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_en |-> !walk_valid);

endmodule

bind morton_addr_gen morton_addr_gen_chk #(.COORD_W(COORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_start (walk_start),
    .walk_en    (walk_en),
    .walk_valid (walk_valid),
    .walk_done  (walk_done),
    .row_off    (row_off),
    .col_off    (col_off)
);

// File: tb/morton_addr_gen_tb.sv
module morton_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] mix_a = '0, mix_b = '0;
    logic [DW-1:0] mix_code;
    logic [DW-1:0] split_code = '0;
    logic [DW-1:0] split_word;
    logic          walk_start = 1'b0;
    logic [CW-1:0] walk_limit = '0;
    logic          walk_en = 1'b0;
    logic          walk_valid, walk_done;
    logic [DW-1:0] row_off, col_off;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    morton_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .mix_a(mix_a), .mix_b(mix_b), .mix_code(mix_code),
        .split_code(split_code), .split_word(split_word),
        .walk_start(walk_start), .walk_limit(walk_limit), .walk_en(walk_en),
        .walk_valid(walk_valid), .walk_done(walk_done),
        .row_off(row_off), .col_off(col_off)
    );

    // Reference: spread bits of v onto even positions.
    function automatic logic [DW-1:0] ref_spread(input logic [CW-1:0] v);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < CW; i++) r[2*i] = v[i];
        return r;
    endfunction

    function automatic logic [DW-1:0] ref_mix(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (ref_spread(a) << 1) | ref_spread(b);
    endfunction

    function automatic logic [DW-1:0] ref_split(input logic [DW-1:0] c);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < CW; i++) begin
            r[CW+i] = c[2*i+1];
            r[i]    = c[2*i];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R4 valid after reset", {31'b0, walk_valid}, 32'd0);
        check("R4 done after reset", {31'b0, walk_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R4 idle until start", {31'b0, walk_done}, 32'd0);
    endtask

    task automatic one_mix(input logic [CW-1:0] a, input logic [CW-1:0] b);
        mix_a = a; mix_b = b;
        #1;
        check("R1 interleave", mix_code, ref_mix(a, b));
        split_code = mix_code;
        #1;
        check("R3 round trip", split_word, {a, b});
    endtask

    task automatic t_mix();
        @(negedge clk);
        one_mix(16'h0000, 16'h0000);
        one_mix(16'hFFFF, 16'hFFFF);
        one_mix(16'hAAAA, 16'h5555);
        one_mix(16'h5555, 16'hAAAA);
        one_mix(16'h8000, 16'h0001);
        one_mix(16'hFFFF, 16'h0000);
        for (int i = 0; i < 40; i++) one_mix(CW'($urandom), CW'($urandom));
    endtask

    task automatic t_split();
        logic [DW-1:0] c;
        for (int i = 0; i < 20; i++) begin
            c = (i == 0) ? 32'hAAAAAAAA : (i == 1) ? 32'h55555555 : $urandom;
            split_code = c;
            #1;
            check("R2 de-interleave", split_word, ref_split(c));
        end
        split_code = 32'h80000001;
        #1;
        check("R2 corner", split_word, 32'h80000001);
    endtask

    // Start a walk of bound p; when gap is set, drop the enable at step 2.
    task automatic t_walk(input logic [CW-1:0] p, input bit gap);
        @(negedge clk);
        walk_start = 1'b1; walk_limit = p; walk_en = 1'b1;
        #1;
        check("R5 no valid in start cycle", {31'b0, walk_valid}, 32'd0);
        @(negedge clk);
        walk_start = 1'b0;
        for (int k = 0; k < p; k++) begin
            if (gap && k == 2) begin
                walk_en = 1'b0;
                #1;
                check("R6 no valid without enable", {31'b0, walk_valid}, 32'd0);
                @(negedge clk);
                #1;
                check("R6 index held", row_off, ref_spread(CW'(k)));
                walk_en = 1'b1;
            end
            #1;
            check("R6 valid while below bound", {31'b0, walk_valid}, 32'd1);
            check("R7 row offset", row_off, ref_spread(CW'(k)));
            check("R7 column offset", col_off, ref_spread(CW'(k)) << 1);
            @(negedge clk);
        end
        #1;
        check("R8 done at bound", {31'b0, walk_done}, 32'd1);
        check("R8 no valid when done", {31'b0, walk_valid}, 32'd0);
        @(negedge clk);
        #1;
        check("R8 done held", {31'b0, walk_done}, 32'd1);
        walk_en = 1'b0;
    endtask

    task automatic t_zero();
        @(negedge clk);
        walk_start = 1'b1; walk_limit = '0; walk_en = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        #1;
        check("R9 done at once", {31'b0, walk_done}, 32'd1);
        check("R9 no valid", {31'b0, walk_valid}, 32'd0);
        walk_en = 1'b0;
    endtask

    task automatic t_restart();
        @(negedge clk);
        walk_start = 1'b1; walk_limit = 16'd20; walk_en = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        repeat (5) @(negedge clk);
        walk_start = 1'b1; walk_limit = 16'd3;
        @(negedge clk);
        walk_start = 1'b0;
        #1;
        check("R10 restart index", row_off, 32'd0);
        check("R10 restart valid", {31'b0, walk_valid}, 32'd1);
        repeat (3) @(negedge clk);
        #1;
        check("R10 new bound done", {31'b0, walk_done}, 32'd1);
        walk_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mix();
        t_split();
        t_zero();
        t_walk(16'd1, 1'b0);
        t_walk(16'd9, 1'b1);
        t_walk(16'd70, 1'b0);
        t_restart();
        t_walk(16'd5, 1'b0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule